// File: doc/BRIEF.md
# NAND Flash Bus Cycle Sequencer

This block turns a single-cycle host request into the command, address and data cycles of an 8-bit asynchronous NAND flash bus. The host gives an operation code, a column, a row and a byte count. The block then drives chip enable, the command and address latch strobes, the write and read strobes, and the outgoing byte with its output enable. Write data is pulled from the host one byte at a time. Read data is handed back one byte at a time with a valid pulse.

For operations that start an internal array access, the block waits for the ready/busy line to return high before it finishes. The line passes through a two-flop synchronizer, and a short guard window gives the device time to pull it low first. A wait that runs past a host-set cycle limit ends the operation with a timeout flag. A request that would start a new array command while the device reports busy is refused, with one exception: the device reset and status read operations are always accepted.

Each operation sends only the address bytes it needs. A page read or a program sends all five. A random data input sends only the two column bytes. An erase sends only the three row bytes.

Top module: `nfc_bus_seq`

## Requirements
- R1: After reset, ce_n, we_n and re_n are high, and cle, ale, io_oe, done, rej and rd_valid are low.
- R2: Each command cycle holds cle high, ale low and io_oe high, with the opcode on io_out when we_n rises. Operation codes on op and their opcodes are as follows. 0 is device reset (FFh). 1 is read ID (90h). 2 is status read (70h). 3 is page read (00h, later 30h). 4 is page program (80h, later 10h). 5 is random data input (85h). 6 is block erase (60h, later D0h).
- R3: Each address cycle holds ale high, cle low and io_oe high. The five address bytes are, in order: col[7:0], {4'b0,col[11:8]}, row[7:0], row[15:8], {7'b0,row[16]}. Here row[5:0] is the page and row[16:6] is the block.
- R4: Page read and program send all five address bytes. Random data input sends only bytes 1 and 2. Erase sends only bytes 3 to 5. Read ID sends one byte, col[7:0]. Reset and status read send none.
- R5: Program and random data input send len data bytes with cle and ale low. The bytes are taken from wr_data in order, and each byte is acknowledged by one wr_take pulse.
- R6: Read ID, status read and page read produce len pulses on re_n. Each pulse returns the io_in value sampled at the rising edge of re_n, on rd_data with a one-cycle rd_valid pulse. io_oe is low whenever re_n is low.
- R7: Every we_n or re_n low phase lasts exactly STB_LO cycles. Every high phase between two pulses lasts at least STB_HI cycles.
- R8: Reset, page read, program and erase wait for the synchronized rb_n to be high before any read cycle and before done. ce_n stays low from acceptance until done. done is a single-cycle pulse, and ce_n is high from that cycle on.
- R9: A request for op 1, 3, 4, 5 or 6 made while the synchronized rb_n is low gives a one-cycle rej pulse and no bus activity. Op 0 and op 2 are accepted in that state.
- R10: If rb_n stays low for tmo_limit cycles of polling, the operation ends with done and tmo_err high. Otherwise tmo_err is low with done.
- R11: A start pulse while an operation is in progress is ignored. It gives no rej and has no effect on the bus sequence.
- R12: Op code 7 is refused with rej and no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse |
| op | input | 3 | Operation code (R2) |
| col | input | COL_W | Column address |
| row | input | ROW_W | Row address (page and block) |
| len | input | LEN_W | Data bytes to write or read |
| tmo_limit | input | TMO_W | Busy polling limit in cycles |
| wr_data | input | 8 | Next write byte |
| wr_take | output | 1 | Write byte consumed |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte valid |
| done | output | 1 | Operation finished |
| tmo_err | output | 1 | Busy wait timed out |
| rej | output | 1 | Request refused |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch strobe |
| ale | output | 1 | Address latch strobe |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_out | output | 8 | Outgoing bus byte |
| io_oe | output | 1 | Bus output enable |
| io_in | input | 8 | Incoming bus byte |
| rb_n | input | 1 | Ready/busy, low when busy |

## Verification
Faults in the stage selection or the address counters appear in the device model's capture log within one bus cycle. They show up as a missing, extra or misplaced address byte, or as a confirm opcode sent at the wrong point. A broken byte counter changes the number of wr_take or rd_valid pulses before the done pulse of the same request. A fault in the busy handling shows up either as read strobes or done arriving while rb_n is low, or as a done that never comes, which the bench's wait limit catches. A fault in the strobe timer changes the measured length of the very next low phase.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [2:0] {
    OP_RST = 3'd0,
    OP_RID = 3'd1,
    OP_STS = 3'd2,
    OP_PRD = 3'd3,
    OP_PRG = 3'd4,
    OP_RIN = 3'd5,
    OP_ERS = 3'd6,
    OP_NUL = 3'd7
  } nfc_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD1, ST_ADDR, ST_WR, ST_CMD2, ST_WAIT, ST_RD, ST_FIN
  } nfc_st_e;

  // per-operation cycle profile
  typedef struct packed {
    logic [7:0] c1;     // first opcode
    logic [7:0] c2;     // confirm opcode
    logic       two;    // confirm opcode present
    logic [2:0] a0;     // first address byte index
    logic [2:0] an;     // number of address bytes
    logic       wr;     // write data phase
    logic       rd;     // read data phase
    logic       bw;     // busy wait
  } nfc_prof_t;

  function automatic nfc_prof_t op_profile(input logic [2:0] op);
    nfc_prof_t p;
    p = '0;
    case (op)
      OP_RST: begin p.c1 = 8'hFF; p.bw = 1'b1; end
      OP_RID: begin p.c1 = 8'h90; p.an = 3'd1; p.rd = 1'b1; end
      OP_STS: begin p.c1 = 8'h70; p.rd = 1'b1; end
      OP_PRD: begin p.c1 = 8'h00; p.c2 = 8'h30; p.two = 1'b1; p.an = 3'd5;
                    p.bw = 1'b1; p.rd = 1'b1; end
      OP_PRG: begin p.c1 = 8'h80; p.c2 = 8'h10; p.two = 1'b1; p.an = 3'd5;
                    p.wr = 1'b1; p.bw = 1'b1; end
      OP_RIN: begin p.c1 = 8'h85; p.an = 3'd2; p.wr = 1'b1; end
      OP_ERS: begin p.c1 = 8'h60; p.c2 = 8'hD0; p.two = 1'b1; p.a0 = 3'd2;
                    p.an = 3'd3; p.bw = 1'b1; end
      default: p = '0;
    endcase
    return p;
  endfunction

  // first stage at or after 'from' that the profile uses
  function automatic nfc_st_e next_stage(input logic [2:0] from, input nfc_prof_t p,
                                         input logic have_bytes);
    nfc_st_e r;
    if (from <= 3'd2 && p.an != 3'd0)               r = ST_ADDR;
    else if (from <= 3'd3 && p.wr && have_bytes)    r = ST_WR;
    else if (from <= 3'd4 && p.two)                 r = ST_CMD2;
    else if (from <= 3'd5 && p.bw)                  r = ST_WAIT;
    else if (from <= 3'd6 && p.rd && have_bytes)    r = ST_RD;
    else                                            r = ST_FIN;
    return r;
  endfunction

endpackage

// File: rtl/nfc_rb_sync.sv
module nfc_rb_sync (
  input  logic clk,
  input  logic rst,
  input  logic rb_n_async,
  output logic rb_s
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= 1'b1;
      rb_s <= 1'b1;
    end else begin
      meta <= rb_n_async;
      rb_s <= meta;
    end
  end
endmodule

// File: rtl/nfc_strobe.sv
module nfc_strobe #(
  parameter int STB_LO = 2,
  parameter int STB_HI = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic rd,
  output logic we_n,
  output logic re_n,
  output logic fin,
  output logic cap
);
  localparam int MAXP = (STB_LO > STB_HI) ? STB_LO : STB_HI;
  localparam int CW   = $clog2(MAXP + 1);

  typedef enum logic [1:0] {P_IDLE, P_LOW, P_HIGH} ph_e;
  ph_e           ph;
  logic [CW-1:0] cnt;
  logic          rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= P_IDLE;
      cnt  <= '0;
      rd_q <= 1'b0;
      we_n <= 1'b1;
      re_n <= 1'b1;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (ph)
        P_IDLE: if (go) begin
          rd_q <= rd;
          if (rd) re_n <= 1'b0;
          else    we_n <= 1'b0;
          cnt <= CW'(STB_LO - 1);
          ph  <= P_LOW;
        end
        P_LOW: if (cnt == '0) begin
          we_n <= 1'b1;
          re_n <= 1'b1;
          cnt  <= CW'(STB_HI - 1);
          ph   <= P_HIGH;
        end else cnt <= cnt - 1'b1;
        P_HIGH: if (cnt == '0) begin
          fin <= 1'b1;
          ph  <= P_IDLE;
        end else cnt <= cnt - 1'b1;
        default: ph <= P_IDLE;
      endcase
    end
  end

  // the last low cycle of a read pulse: sample the bus at the rising edge
  assign cap = (ph == P_LOW) && (cnt == '0) && rd_q;

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));
  assert_go_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    go |-> (ph == P_IDLE));
endmodule

// File: rtl/nfc_busy_watch.sv
module nfc_busy_watch #(
  parameter int GUARD = 4,
  parameter int TMO_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             rb_s,
  input  logic [TMO_W-1:0] limit,
  output logic             rdy,
  output logic             expired
);
  localparam int GW = $clog2(GUARD + 1);

  typedef enum logic [1:0] {W_OFF, W_GUARD, W_POLL} wph_e;
  wph_e             ph;
  logic [GW-1:0]    gcnt;
  logic [TMO_W-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= W_OFF;
      gcnt    <= '0;
      tcnt    <= '0;
      rdy     <= 1'b0;
      expired <= 1'b0;
    end else begin
      rdy     <= 1'b0;
      expired <= 1'b0;
      case (ph)
        W_OFF: if (arm) begin
          gcnt <= GW'(GUARD - 1);
          tcnt <= '0;
          ph   <= W_GUARD;
        end
        W_GUARD: if (gcnt == '0) ph <= W_POLL;
                 else gcnt <= gcnt - 1'b1;
        W_POLL: if (rb_s) begin
          rdy <= 1'b1;
          ph  <= W_OFF;
        end else if (tcnt >= limit) begin
          expired <= 1'b1;
          ph      <= W_OFF;
        end else tcnt <= tcnt + 1'b1;
        default: ph <= W_OFF;
      endcase
    end
  end

  assert_ready_seen_R8: assert property (@(posedge clk) disable iff (rst)
    rdy |-> $past(rb_s));
  assert_timeout_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
    expired |-> $past(!rb_s));
endmodule

// File: rtl/nfc_bus_seq.sv
module nfc_bus_seq
  import nfc_pkg::*;
#(
  parameter int COL_W  = 12,
  parameter int ROW_W  = 17,
  parameter int LEN_W  = 12,
  parameter int TMO_W  = 24,
  parameter int STB_LO = 2,
  parameter int STB_HI = 1,
  parameter int GUARD  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  logic [LEN_W-1:0] len,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             tmo_err,
  output logic             rej,
  output logic             ce_n,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [7:0]       io_out,
  output logic             io_oe,
  input  logic [7:0]       io_in,
  input  logic             rb_n
);
  localparam int AV_W = 40;

  logic             rb_s;
  nfc_st_e          st, st_n;
  logic [2:0]       op_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [LEN_W-1:0] len_q, bleft, bleft_n;
  logic [2:0]       aidx, aleft, aidx_n, aleft_n;
  logic             go, go_rd, fin, cap, arm, rdy, expd;
  logic             adv, accept, refuse, legal, busy_ok;
  nfc_prof_t        pf;
  logic [AV_W-1:0]  av;

  nfc_rb_sync u_sync (.clk(clk), .rst(rst), .rb_n_async(rb_n), .rb_s(rb_s));

  nfc_strobe #(.STB_LO(STB_LO), .STB_HI(STB_HI)) u_stb (
    .clk(clk), .rst(rst), .go(go), .rd(go_rd),
    .we_n(we_n), .re_n(re_n), .fin(fin), .cap(cap));

  nfc_busy_watch #(.GUARD(GUARD), .TMO_W(TMO_W)) u_bw (
    .clk(clk), .rst(rst), .arm(arm), .rb_s(rb_s), .limit(tmo_limit),
    .rdy(rdy), .expired(expd));

  assign pf      = op_profile((st == ST_IDLE) ? op : op_q);
  assign legal   = (op != OP_NUL);
  assign busy_ok = rb_s || (op == OP_RST) || (op == OP_STS);
  assign accept  = start && (st == ST_IDLE) && legal && busy_ok;
  assign refuse  = start && (st == ST_IDLE) && !(legal && busy_ok);
  assign av      = (AV_W'(row_q) << 16) | AV_W'(col_q);

  always_comb begin
    adv     = 1'b0;
    st_n    = st;
    aidx_n  = aidx;
    aleft_n = aleft;
    bleft_n = bleft;
    case (st)
      ST_IDLE: if (accept) begin
        adv = 1'b1; st_n = ST_CMD1; aidx_n = pf.a0; aleft_n = pf.an;
      end
      ST_CMD1: if (fin) begin
        adv = 1'b1; bleft_n = len_q;
        st_n = next_stage(3'd1, pf, len_q != '0);
      end
      ST_ADDR: if (fin) begin
        adv = 1'b1;
        if (aleft != 3'd1) begin
          aidx_n = aidx + 3'd1; aleft_n = aleft - 3'd1;
        end else st_n = next_stage(3'd3, pf, len_q != '0);
      end
      ST_WR: if (fin) begin
        adv = 1'b1;
        if (bleft != LEN_W'(1)) bleft_n = bleft - 1'b1;
        else st_n = next_stage(3'd4, pf, len_q != '0);
      end
      ST_CMD2: if (fin) begin
        adv = 1'b1; st_n = next_stage(3'd5, pf, len_q != '0);
      end
      ST_WAIT: if (expd) begin
        adv = 1'b1; st_n = ST_FIN;
      end else if (rdy) begin
        adv = 1'b1; st_n = next_stage(3'd6, pf, len_q != '0);
      end
      ST_RD: if (fin) begin
        adv = 1'b1;
        if (bleft != LEN_W'(1)) bleft_n = bleft - 1'b1;
        else st_n = ST_FIN;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; op_q <= '0; col_q <= '0; row_q <= '0; len_q <= '0;
      aidx <= '0; aleft <= '0; bleft <= '0;
      ce_n <= 1'b1; cle <= 1'b0; ale <= 1'b0; io_oe <= 1'b0; io_out <= '0;
      go <= 1'b0; go_rd <= 1'b0; arm <= 1'b0;
      done <= 1'b0; rej <= 1'b0; tmo_err <= 1'b0;
      wr_take <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      go <= 1'b0; arm <= 1'b0; done <= 1'b0; rej <= 1'b0;
      wr_take <= 1'b0; rd_valid <= 1'b0;
      if (refuse) rej <= 1'b1;
      if (cap) begin
        rd_data  <= io_in;
        rd_valid <= 1'b1;
      end
      if (accept) begin
        op_q <= op; col_q <= col; row_q <= row; len_q <= len;
        ce_n <= 1'b0; tmo_err <= 1'b0;
      end
      if (adv) begin
        aidx <= aidx_n; aleft <= aleft_n; bleft <= bleft_n;
        st   <= (st_n == ST_FIN) ? ST_IDLE : st_n;
        cle  <= 1'b0; ale <= 1'b0; io_oe <= 1'b0; go_rd <= 1'b0;
        case (st_n)
          ST_CMD1: begin cle <= 1'b1; io_oe <= 1'b1; io_out <= pf.c1; go <= 1'b1; end
          ST_ADDR: begin
            ale <= 1'b1; io_oe <= 1'b1; go <= 1'b1;
            io_out <= av[{aidx_n, 3'b000} +: 8];
          end
          ST_WR:   begin io_oe <= 1'b1; io_out <= wr_data; wr_take <= 1'b1; go <= 1'b1; end
          ST_CMD2: begin cle <= 1'b1; io_oe <= 1'b1; io_out <= pf.c2; go <= 1'b1; end
          ST_WAIT: arm <= 1'b1;
          ST_RD:   begin go <= 1'b1; go_rd <= 1'b1; end
          ST_FIN:  begin
            ce_n <= 1'b1; done <= 1'b1;
            if (st == ST_WAIT && expd) tmo_err <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assert_latches_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(cle && ale));
  assert_oe_off_when_reading_R6: assert property (@(posedge clk) disable iff (rst)
    !re_n |-> !io_oe);
  assert_write_drives_bus_R5: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> io_oe);
  assert_strobe_needs_ce_R8: assert property (@(posedge clk) disable iff (rst)
    (!we_n || !re_n) |-> !ce_n);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_refuse_keeps_idle_R9: assert property (@(posedge clk) disable iff (rst)
    rej |-> ce_n);
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (start && !ce_n) |=> !rej);
  assert_timeout_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo_err) |-> done);
endmodule

// File: tb/test_nfc_bus_seq.sv
module test_nfc_bus_seq;
  localparam int CLK_P = 10;
  localparam int LO = 2;
  localparam int HI = 1;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0] op = '0;
  logic [11:0] col = '0, len = '0;
  logic [16:0] row = '0;
  logic [23:0] tmo_limit = 24'd2000;
  logic [7:0] wr_data = '0, rd_data, io_out, io_in;
  logic wr_take, rd_valid, done, tmo_err, rej, ce_n, cle, ale, we_n, re_n, io_oe;
  logic rb_n = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  nfc_bus_seq #(.STB_LO(LO), .STB_HI(HI)) i_nfc_bus_seq (
    .clk(clk), .rst(rst), .start(start), .op(op), .col(col), .row(row), .len(len),
    .tmo_limit(tmo_limit), .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data),
    .rd_valid(rd_valid), .done(done), .tmo_err(tmo_err), .rej(rej), .ce_n(ce_n),
    .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .io_out(io_out), .io_oe(io_oe),
    .io_in(io_in), .rb_n(rb_n));

  int nchk = 0, nfail = 0;
  int lg_t[64]; int lg_v[64]; int nlog = 0;
  int ex_t[64]; int ex_v[64]; int nex = 0;
  int rdl[64]; int nrd = 0;
  int rd_idx = 0, widx = 0, busy_len = 10, mcnt = 0, cyc = 0;
  int ndone = 0, nrej = 0, bad_we = 0, bad_re = 0, bad_oe = 0, bad_rdb = 0;
  int we_lo = 0, we_hi = 0, re_lo = 0, re_hi = 0, ce_idle_low = 0, nwe = 0;
  bit pend = 0, mbusy = 0, hold_low = 0, last_tmo = 0;

  function automatic logic [7:0] wpat(input int i); return 8'(i * 37 + 11); endfunction
  function automatic logic [7:0] rpat(input int i); return 8'(i * 29 + 8'h3C); endfunction
  assign io_in = rpat(rd_idx);

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // device model: capture cycles on the write strobe rising edge
  always @(posedge we_n) if (!rst && !ce_n && nlog < 64) begin
    lg_t[nlog] = cle ? 1 : (ale ? 2 : 3);
    lg_v[nlog] = io_out;
    nlog++;
    if (!io_oe) bad_oe++;
    if (cle) begin
      rd_idx = 0;
      if (io_out == 8'hFF || io_out == 8'h30 || io_out == 8'h10 || io_out == 8'hD0) pend = 1;
    end
  end
  always @(posedge re_n) if (!rst && !ce_n) rd_idx++;

  always @(negedge clk) begin
    cyc++;
    if (pend) begin mbusy = 1; mcnt = busy_len; pend = 0; end
    else if (mbusy) begin if (mcnt == 0) mbusy = 0; else mcnt--; end
    rb_n = !(mbusy || hold_low);
    if (!rst) begin
      if (!we_n) begin
        if (we_lo == 0 && nwe > 0 && we_hi < HI) bad_we++;
        we_lo++; we_hi = 0;
      end else begin
        if (we_lo != 0) begin if (we_lo != LO) bad_we++; nwe++; end
        we_lo = 0; we_hi++;
      end
      if (!re_n) begin
        if (re_lo == 0 && re_hi < HI) bad_re++;
        re_lo++; re_hi = 0;
      end else begin
        if (re_lo != 0 && re_lo != LO) bad_re++;
        re_lo = 0; re_hi++;
      end
      if (!re_n && io_oe) bad_oe++;
      if (!re_n && !rb_n && !hold_low) bad_rdb++;
      if (rd_valid && nrd < 64) begin rdl[nrd] = rd_data; nrd++; end
      if (wr_take) begin widx++; wr_data = wpat(widx); end
      if (rej) nrej++;
      if (done) begin ndone++; last_tmo = tmo_err; end
    end
  end

  task automatic add(input int t, input int v); ex_t[nex] = t; ex_v[nex] = v; nex++; endtask

  task automatic build(input logic [2:0] o, input logic [11:0] c, input logic [16:0] r,
                       input int n);
    int b[5];
    b[0] = c[7:0]; b[1] = {4'b0, c[11:8]}; b[2] = r[7:0]; b[3] = r[15:8]; b[4] = {7'b0, r[16]};
    nex = 0;
    case (o)
      3'd0: add(1, 8'hFF);
      3'd1: begin add(1, 8'h90); add(2, b[0]); end
      3'd2: add(1, 8'h70);
      3'd3: begin add(1, 8'h00); for (int k = 0; k < 5; k++) add(2, b[k]); add(1, 8'h30); end
      3'd4: begin add(1, 8'h80); for (int k = 0; k < 5; k++) add(2, b[k]);
                  for (int k = 0; k < n; k++) add(3, wpat(k)); add(1, 8'h10); end
      3'd5: begin add(1, 8'h85); add(2, b[0]); add(2, b[1]);
                  for (int k = 0; k < n; k++) add(3, wpat(k)); end
      3'd6: begin add(1, 8'h60); for (int k = 2; k < 5; k++) add(2, b[k]); add(1, 8'hD0); end
      default: nex = 0;
    endcase
  endtask

  task automatic launch(input logic [2:0] o, input logic [11:0] c, input logic [16:0] r,
                        input logic [11:0] n, input int bl);
    nlog = 0; nrd = 0; widx = 0; wr_data = wpat(0); busy_len = bl;
    op = o; col = c; row = r; len = n; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    for (int k = 0; k < 20000 && ndone == d0; k++) begin @(posedge clk); #1; end
    @(posedge clk); #1;
  endtask

  task automatic verify(input logic [2:0] o, input logic [11:0] c, input logic [16:0] r,
                        input int n, input int d0);
    build(o, c, r, n);
    chk("R8 done pulse count", ndone - d0, 1);
    chk("R4 bus cycle count", nlog, nex);
    for (int k = 0; k < nex && k < nlog; k++) begin
      chk((ex_t[k] == 1) ? "R2 command cycle" : (ex_t[k] == 2) ? "R3 address cycle" :
          "R5 data cycle", lg_t[k] * 256 + lg_v[k], ex_t[k] * 256 + ex_v[k]);
    end
    if (o == 3'd1 || o == 3'd2 || o == 3'd3) begin
      chk("R6 read byte count", nrd, n);
      for (int k = 0; k < nrd; k++) chk("R6 read byte", rdl[k], rpat(k));
    end else chk("R6 no reads", nrd, 0);
    if (o == 3'd4 || o == 3'd5) chk("R5 wr_take count", widx, n);
    chk("R10 no timeout", last_tmo, 0);
    chk("R8 ce_n high after done", ce_n, 1);
  endtask

  task automatic settle();
    while (!rb_n) begin @(posedge clk); #1; end
    repeat (4) @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    int d0, t0, s;
    logic [2:0] o; logic [11:0] c, n; logic [16:0] r;
    s = $urandom(32'd4242);
    repeat (5) @(posedge clk); #1;
    chk("R1 ce_n", ce_n, 1); chk("R1 we_n", we_n, 1); chk("R1 re_n", re_n, 1);
    chk("R1 cle/ale/io_oe", {cle, ale, io_oe}, 0);
    chk("R1 done/rej/rd_valid", {done, rej, rd_valid}, 0);
    rst = 1'b0;
    repeat (3) @(posedge clk); #1;

    // directed: each operation, boundary column 2111 and top row bit
    for (int k = 0; k < 7; k++) begin
      d0 = ndone;
      launch(3'(k), 12'd2111, 17'h1FFFF, 12'd3, 12);
      wait_done(d0);
      verify(3'(k), 12'd2111, 17'h1FFFF, 3, d0);
      settle();
    end

    // R8: program waits for the busy period before done; ce_n held low
    d0 = ndone; t0 = cyc;
    launch(3'd4, 12'h001, 17'h00040, 12'd2, 60);
    repeat (20) @(posedge clk); #1;
    chk("R8 ce_n low mid operation", ce_n, 0);
    wait_done(d0);
    chk("R8 done after busy", (cyc - t0) > 60, 1);
    verify(3'd4, 12'h001, 17'h00040, 2, d0);
    settle();

    // R11: second start mid operation is ignored
    d0 = ndone; t0 = nrej;
    launch(3'd4, 12'h123, 17'h0ABCD, 12'd3, 20);
    repeat (10) @(posedge clk); #1;
    op = 3'd6; start = 1'b1; @(posedge clk); #1; start = 1'b0;
    op = 3'd4;
    wait_done(d0);
    verify(3'd4, 12'h123, 17'h0ABCD, 3, d0);
    chk("R11 no reject for ignored start", nrej - t0, 0);
    settle();

    // R9: refused while busy, status accepted
    hold_low = 1; repeat (4) @(posedge clk); #1;
    t0 = nrej; d0 = ndone;
    launch(3'd3, 12'h010, 17'h00100, 12'd2, 10);
    repeat (12) @(posedge clk); #1;
    chk("R9 reject pulse", nrej - t0, 1);
    chk("R9 no bus cycles", nlog, 0);
    chk("R9 no done", ndone - d0, 0);
    d0 = ndone;
    launch(3'd2, 12'h0, 17'h0, 12'd1, 10);
    wait_done(d0);
    verify(3'd2, 12'h0, 17'h0, 1, d0);

    // R10: reset accepted while busy, times out
    tmo_limit = 24'd30; d0 = ndone;
    launch(3'd0, 12'h0, 17'h0, 12'd0, 5);
    wait_done(d0);
    chk("R10 timeout done", ndone - d0, 1);
    chk("R10 tmo_err set", last_tmo, 1);
    chk("R10 reset cycle sent", nlog * 256 + lg_v[0], 256 + 8'hFF);
    hold_low = 0; tmo_limit = 24'd2000;
    settle();

    // R12: undefined op refused
    t0 = nrej;
    launch(3'd7, 12'h0, 17'h0, 12'd1, 5);
    repeat (8) @(posedge clk); #1;
    chk("R12 reject pulse", nrej - t0, 1);
    chk("R12 no bus cycles", nlog, 0);

    // random mix
    for (int k = 0; k < 40; k++) begin
      o = 3'($urandom % 7); c = 12'($urandom % 2112); r = 17'($urandom);
      n = 12'($urandom % 5);
      d0 = ndone;
      launch(o, c, r, n, 3 + int'($urandom % 30));
      wait_done(d0);
      verify(o, c, r, int'(n), d0);
      settle();
    end

    chk("R7 write strobe timing violations", bad_we, 0);
    chk("R7 read strobe timing violations", bad_re, 0);
    chk("R6 output enable overlaps", bad_oe, 0);
    chk("R8 reads while busy", bad_rdb, 0);
    chk("R7 write strobes seen", nwe > 50, 1);
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule